// File: doc/BRIEF.md
# Overcurrent pulse-skipping gate

This block sits between a PWM generator and the driver of a single power switch and protects the stage cycle by cycle. Each switching period begins with a one-clock start tick. The PWM generator raises an on-request, and the block passes it to the switch drive as one pulse per period. A digital overcurrent flag from an external comparator is ignored for a programmable blanking window after each turn-on. This keeps switching noise from being taken as a fault.

The block checks the flag once, in the clock where blanking ends, and this check sets the protection level. A fault at that point ends the pulse at once and raises a skip level that is held between 0 and a ceiling of 7. The block then suppresses that many following periods completely. A clean check lowers the level by one. Under a sustained short the stage therefore falls back to one conducted period in eight, and it recovers gradually as the load clears. After blanking, a raised flag still ends the pulse, but it does not change the skip level.

Top module: `ocp_skip_gate`

## Requirements
- R1: While reset is low the drive is low. After reset the skip level is zero, so the first faulted period is followed by exactly one skipped period.
- R2: With no skips pending, the drive rises on the clock edge that samples the start tick with the on-request high, or on the first later edge in that period that samples the on-request high. It falls on the edge that samples the on-request low.
- R3: After a period's pulse has ended, the drive stays low until the next start tick, even if the on-request rises again.
- R4: For the first BLANK_CLKS clocks of a pulse, the overcurrent flag is ignored and the drive stays high while the on-request is high.
- R5: A flag that is high in the clock where blanking ends takes the drive low on that edge, so the pulse lasts exactly BLANK_CLKS clocks. The same fault raises the skip level by one, up to a ceiling of MAX_SKIP (7).
- R6: After a fault, the next N start ticks, where N is the new skip level, produce no drive for their whole period. The on-request and the flag have no effect during these periods, and the skip level stays unchanged.
- R7: A flag that is low in the clock where blanking ends lowers the skip level by one, and the level does not go below zero.
- R8: A flag that rises after blanking ends takes the drive low on the next edge, and the skip level stays unchanged.
- R9: A pulse that ends before its blanking window is over leaves the skip level unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-clock pulse that starts each switching period |
| pwm_req | input | 1 | Raw on-request from the PWM modulator |
| oc_flag | input | 1 | Digital overcurrent comparator output |
| drive | output | 1 | Gated power-switch drive, registered |

## Verification
The bench applies a sustained fault for eight conducted periods. It expects skip runs of 1, 2 and so on up to 7, and then 7 again. A design with no ceiling would skip 8 periods, and a design that reloads the skip level from the wrong value would give runs that are too short.

Recovery is measured by putting clean periods between faults. A design whose decrement wraps or stalls would produce the wrong run length after the next fault.

A flag held only inside the blanking window must not cut the pulse short. A flag that rises after blanking must end the pulse without raising the level, and a pulse that ends inside blanking must not count as a clean check. A design that mixes up these cases shows the wrong pulse width or the wrong skip count afterwards.

A second on-request within one period checks that there is only one pulse per period.

// File: rtl/ocp_skip_gate.sv
module ocp_skip_gate #(
  parameter int BLANK_CLKS = 20,
  parameter int MAX_SKIP   = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic pwm_req,
  input  logic oc_flag,
  output logic drive
);
  localparam int CW = $clog2(MAX_SKIP + 1);
  localparam int BW = $clog2(BLANK_CLKS + 1);

  logic [CW-1:0] skip_lvl;
  logic [CW-1:0] skip_rem;
  logic [BW-1:0] on_age;
  logic          armed;

  wire blank_end  = drive && (on_age == BW'(BLANK_CLKS - 1));
  wire post_blank = drive && (on_age == BW'(BLANK_CLKS));

  wire [CW-1:0] lvl_up = (skip_lvl == CW'(MAX_SKIP)) ? skip_lvl : skip_lvl + 1'b1;
  wire [CW-1:0] lvl_dn = (skip_lvl == '0) ? skip_lvl : skip_lvl - 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      drive    <= 1'b0;
      armed    <= 1'b0;
      on_age   <= '0;
      skip_lvl <= '0;
      skip_rem <= '0;
    end else if (tick) begin
      if (skip_rem != '0) begin
        skip_rem <= skip_rem - 1'b1;
        armed    <= 1'b0;
        drive    <= 1'b0;
      end else begin
        armed  <= 1'b1;
        drive  <= pwm_req;
        on_age <= '0;
      end
    end else if (blank_end) begin
      if (oc_flag) begin
        drive    <= 1'b0;
        armed    <= 1'b0;
        skip_lvl <= lvl_up;
        skip_rem <= lvl_up;
      end else begin
        skip_lvl <= lvl_dn;
        on_age   <= on_age + 1'b1;
        if (!pwm_req) begin
          drive <= 1'b0;
          armed <= 1'b0;
        end
      end
    end else if (drive) begin
      if (!pwm_req || (post_blank && oc_flag)) begin
        drive <= 1'b0;
        armed <= 1'b0;
      end else if (!post_blank) begin
        on_age <= on_age + 1'b1;
      end
    end else if (armed && pwm_req) begin
      drive  <= 1'b1;
      on_age <= '0;
    end
  end
endmodule

// File: rtl/ocp_skip_gate_sva.sv
module ocp_skip_gate_sva #(
  parameter int BLANK_CLKS = 20,
  parameter int MAX_SKIP   = 7,
  parameter int CW         = 3,
  parameter int BW         = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick,
  input logic          pwm_req,
  input logic          oc_flag,
  input logic          drive,
  input logic          armed,
  input logic [BW-1:0] on_age,
  input logic [CW-1:0] skip_lvl,
  input logic [CW-1:0] skip_rem
);
  assert_reset_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !drive);

  assert_rise_on_request_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drive) |-> $past(pwm_req));

  assert_one_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed && !drive && !tick) |=> !drive);

  assert_blank_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (drive && on_age < BW'(BLANK_CLKS - 1) && pwm_req && !tick) |=> drive);

  assert_fault_cut_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (drive && on_age == BW'(BLANK_CLKS - 1) && oc_flag && !tick) |=>
      (!drive && skip_lvl == (($past(skip_lvl) == CW'(MAX_SKIP)) ? CW'(MAX_SKIP) : CW'($past(skip_lvl) + 1'b1))));

  assert_skip_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && skip_rem != '0) |=> (!drive && $stable(skip_lvl)));

  assert_clean_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (drive && on_age == BW'(BLANK_CLKS - 1) && !oc_flag && !tick) |=>
      (skip_lvl == (($past(skip_lvl) == '0) ? '0 : CW'($past(skip_lvl) - 1'b1))));

  assert_late_cut_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (drive && on_age == BW'(BLANK_CLKS) && oc_flag && !tick) |=> (!drive && $stable(skip_lvl)));

  assert_early_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (drive && on_age < BW'(BLANK_CLKS - 1) && !pwm_req && !tick) |=> $stable(skip_lvl));
endmodule

bind ocp_skip_gate ocp_skip_gate_sva #(
  .BLANK_CLKS(BLANK_CLKS), .MAX_SKIP(MAX_SKIP), .CW(CW), .BW(BW)
) u_sva (
  .clk(clk), .rst_n(rst_n), .tick(tick), .pwm_req(pwm_req), .oc_flag(oc_flag),
  .drive(drive), .armed(armed), .on_age(on_age), .skip_lvl(skip_lvl), .skip_rem(skip_rem)
);

// File: tb/ocp_skip_gate_bench.sv
`timescale 1ns/1ps
module ocp_skip_gate_bench;
  localparam int B = 6;
  localparam int P = 20;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, pwm_req = 1'b0, oc_flag = 1'b0;
  logic drive;
  int checks = 0, errors = 0;
  bit done = 0;

  ocp_skip_gate #(.BLANK_CLKS(B), .MAX_SKIP(7)) u_ocp_skip_gate (
    .clk(clk), .rst_n(rst_n), .tick(tick), .pwm_req(pwm_req), .oc_flag(oc_flag), .drive(drive));

  always #2.5 clk = ~clk;

  // behavioural reference: pulse phase, age, level and pending skips as integers
  int  m_lvl = 0, m_rem = 0, m_age = 0;
  bit  m_on = 0, m_may = 0;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_on = 0; m_may = 0; m_age = 0; m_lvl = 0; m_rem = 0;
    end else if (tick) begin
      if (m_rem > 0) begin m_rem--; m_may = 0; m_on = 0; end
      else begin m_may = 1; m_on = pwm_req; m_age = 0; end
    end else if (m_on) begin
      if (m_age == B - 1) begin
        if (oc_flag) begin
          m_on = 0; m_may = 0;
          m_lvl = (m_lvl < 7) ? m_lvl + 1 : 7;
          m_rem = m_lvl;
        end else begin
          m_lvl = (m_lvl > 0) ? m_lvl - 1 : 0;
          m_age++;
          if (!pwm_req) begin m_on = 0; m_may = 0; end
        end
      end else if (!pwm_req || (m_age >= B && oc_flag)) begin
        m_on = 0; m_may = 0;
      end else if (m_age < B) m_age++;
    end else if (m_may && pwm_req) begin
      m_on = 1; m_age = 0;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n && !done)
    check(drive === m_on, (m_rem > 0) ? "R6 per-clock" : "R2/R4 per-clock", int'(drive), int'(m_on));

  // one period: on-request in [a0,a1) and [b0,b1), flag in [o0,o1); returns drive-high clocks
  task automatic cyc(input int a0, a1, b0, b1, o0, o1, output int w);
    w = 0;
    for (int i = 0; i <= P; i++) begin
      @(negedge clk);
      if (i > 0 && drive === 1'b1) w++;
      tick    = (i == 0);
      pwm_req = (i < P) && ((i >= a0 && i < a1) || (i >= b0 && i < b1));
      oc_flag = (i < P) && (i >= o0 && i < o1);
    end
  endtask

  task automatic fault_then(input int n, input string tag);
    int w;
    cyc(0, 12, 0, 0, 0, P, w);
    check(w == B, {tag, " fault width"}, w, B);
    for (int s = 0; s < n; s++) begin
      cyc(0, 12, 0, 0, 0, P, w);
      check(w == 0, {tag, " skipped period"}, w, 0);
    end
  endtask

  initial begin
    int w;
    repeat (4) @(negedge clk);
    check(drive === 1'b0, "R1 reset drive", int'(drive), 0);
    rst_n = 1'b1;
    cyc(0, 12, 0, 0, 0, 0, w);   check(w == 12, "R2 clean width", w, 12);
    cyc(3, 15, 0, 0, 0, 0, w);   check(w == 12, "R2 late turn-on", w, 12);
    cyc(0, 12, 0, 0, 0, B, w);   check(w == 12, "R4 flag in blanking", w, 12);
    cyc(0, 4, 8, 12, 0, 0, w);   check(w == 4, "R3 second request", w, 4);
    cyc(0, 4, 0, 0, 0, P, w);    check(w == 4, "R9 early end", w, 4);
    cyc(0, 12, 0, 0, 9, P, w);   check(w == 9, "R8 late flag", w, 9);
    fault_then(1, "R1 R8 R9 level zero");
    cyc(0, 12, 0, 0, 0, 0, w);   check(w == 12, "R7 clean after skip", w, 12);
    for (int k = 1; k <= 8; k++) fault_then((k < 7) ? k : 7, "R5 R6 growth");
    for (int j = 0; j < 3; j++) begin
      cyc(0, 12, 0, 0, 0, 0, w); check(w == 12, "R7 recovery width", w, 12);
    end
    fault_then(5, "R7 step down");
    for (int j = 0; j < 8; j++) begin
      cyc(0, 12, 0, 0, 0, 0, w); check(w == 12, "R7 recovery width", w, 12);
    end
    fault_then(1, "R7 floor");
    cyc(0, 12, 0, 0, 0, 0, w);   check(w == 12, "R6 conducts after skips", w, 12);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule